// File: doc/BRIEF.md
# Shift-Register Addressed Sine Sequencer

This block walks through one period of a coarse sine wave, one table step per request, and presents a 4-bit sample code for an external binary-weighted resistor ladder. The step position is not a binary count. It is a 5-bit shift-register address: each step moves the address one place toward bit 0 and enters a freshly computed bit at bit 4. The feedback is nonlinear. A term that detects an all-zero upper field keeps the register from locking at zero, so a full period can use all 32 addresses.

The address drives a decoded lookup plane rather than a binary-indexed ROM. A row of the plane may ignore some address bits. Two positions that carry the same sample value, one on a rising slope and one on a falling slope, can therefore share a single row. The parameter `POINTS` selects a 32-step period or a 29-step period. In the 29-step variant the feedback flips its bit at one address, which skips three states, and the table changes to match. The caller provides the step pulses at whatever rate sets the output frequency.

Top module: `sine_step_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the address is 5'b10000, the sample is 8 and the wrap strobe is low.
- R2: When `step` is high at a rising clock edge, the address bits [4:1] move to [3:0] and a new bit enters at bit 4. When `step` is low, the address and the sample keep their values.
- R3: With POINTS=32 the new bit is bit0 XOR bit2, inverted when bits [4:1] are all zero. One period visits each of the 32 addresses exactly once, 5'b00000 included, and returns to 5'b10000 after exactly 32 steps.
- R4: With POINTS=29 the new bit is also inverted at address 5'b01000, so that address steps to 5'b10100. One period visits 29 distinct addresses, 5'b00000 included, and returns to 5'b10000 after exactly 29 steps.
- R5: With POINTS=32, step k of the period (k=0 at the reset address) yields the code 8,9,10,12,13,14,14,15,15,15,14,14,13,12,10,9,7,6,5,3,2,1,1,0,0,0,1,1,2,3,5,6. The code is unsigned binary, bit n weighted 2^n.
- R6: With POINTS=29, step k yields 8,9,11,12,13,14,15,15,15,14,14,13,11,10,8,7,5,4,2,1,1,0,0,0,1,2,3,4,6.
- R7: Every sample lies within half a code of 7.5+7.5*sin(2*pi*k/POINTS). Over one period the codes rise to a single peak and fall to a single trough.
- R8: Sample bit 3 is set for the steps with 2k < POINTS and clear for the rest of the period.
- R9: Every reachable address matches exactly one lookup row. The address pairs sharing a row, and so a value, are 10100/11100 and 10101/11101 with POINTS=32, and 11110/11111, 01101/01111, 10000/10001, 01010/01110 and 10101/10111 with POINTS=29.
- R10: `wrap` is high for exactly one cycle, the cycle after a step that returns the address to 5'b10000, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Advance one table step at this edge |
| sample | output | 4 | Current sample code for the ladder |
| seq_addr | output | 5 | Current shift-register address |
| wrap | output | 1 | One-cycle strobe on return to the start address |

## Verification
The bench builds the block twice, with POINTS=32 and POINTS=29, and drives both from the same step and reset. The 32-step build exercises the all-zero escape over the whole address space. The 29-step build reaches the forced jump at 01000 and the don't-care rows that only its table uses. Runs with steps back to back and with irregular gaps, plus a reset in mid-period, cover every period length, every address and every merged row in both variants.

// File: rtl/sine_seq_pkg.sv
`timescale 1ns/1ps
package sine_seq_pkg;

  localparam int ADDR_W       = 5;
  localparam int SAMPLE_W     = 4;
  localparam int FULL_POINTS  = 32;
  localparam int SHORT_POINTS = 29;
  localparam int FULL_ROWS    = 30;
  localparam int SHORT_ROWS   = 24;

  typedef logic [ADDR_W-1:0]   addr_t;
  typedef logic [SAMPLE_W-1:0] sample_t;

  // start of every period and the state where the short mode jumps
  localparam addr_t SEED_ADDR = 5'b10000;
  localparam addr_t JUMP_ADDR = 5'b01000;
  localparam addr_t ALL_CARE  = '1;

  // one row of the decode plane: bits with care=0 are wildcards
  typedef struct packed {
    addr_t   care;
    addr_t   match;
    sample_t value;
  } pla_row_t;

  // linear part of the feedback (taps on bits 0 and 2)
  function automatic logic lin_tap(input addr_t a);
    return a[0] ^ a[2];
  endfunction

  // escape term: the bits that survive the shift are all zero
  function automatic logic upper_zero(input addr_t a);
    return (a[ADDR_W-1:1] == '0);
  endfunction

  function automatic addr_t shift_in(input addr_t a, input logic b);
    return {b, a[ADDR_W-1:1]};
  endfunction

  function automatic int row_count(input int points);
    return (points == SHORT_POINTS) ? SHORT_ROWS : FULL_ROWS;
  endfunction

  function automatic pla_row_t mk(input addr_t care, input addr_t match,
                                  input sample_t value);
    pla_row_t r;
    r.care  = care;
    r.match = match;
    r.value = value;
    return r;
  endfunction

  function automatic logic row_hit(input pla_row_t r, input addr_t a);
    return (((a ^ r.match) & r.care) == '0);
  endfunction

  // 32-point table: two rows merge slope pairs with equal values
  function automatic pla_row_t full_row(input int idx);
    case (idx)
      0:  return mk(5'b10111, 5'b10100, 4'd14);
      1:  return mk(5'b10111, 5'b10101, 4'd1);
      2:  return mk(ALL_CARE, 5'b11010, 4'd14);
      3:  return mk(ALL_CARE, 5'b11001, 4'd14);
      4:  return mk(ALL_CARE, 5'b10000, 4'd8);
      5:  return mk(ALL_CARE, 5'b01000, 4'd9);
      6:  return mk(ALL_CARE, 5'b00100, 4'd10);
      7:  return mk(ALL_CARE, 5'b10010, 4'd12);
      8:  return mk(ALL_CARE, 5'b01001, 4'd13);
      9:  return mk(ALL_CARE, 5'b01101, 4'd15);
      10: return mk(ALL_CARE, 5'b00110, 4'd15);
      11: return mk(ALL_CARE, 5'b10011, 4'd15);
      12: return mk(ALL_CARE, 5'b11110, 4'd13);
      13: return mk(ALL_CARE, 5'b11111, 4'd12);
      14: return mk(ALL_CARE, 5'b01111, 4'd10);
      15: return mk(ALL_CARE, 5'b00111, 4'd9);
      16: return mk(ALL_CARE, 5'b00011, 4'd7);
      17: return mk(ALL_CARE, 5'b10001, 4'd6);
      18: return mk(ALL_CARE, 5'b11000, 4'd5);
      19: return mk(ALL_CARE, 5'b01100, 4'd3);
      20: return mk(ALL_CARE, 5'b10110, 4'd2);
      21: return mk(ALL_CARE, 5'b11011, 4'd1);
      22: return mk(ALL_CARE, 5'b01110, 4'd0);
      23: return mk(ALL_CARE, 5'b10111, 4'd0);
      24: return mk(ALL_CARE, 5'b01011, 4'd0);
      25: return mk(ALL_CARE, 5'b01010, 4'd1);
      26: return mk(ALL_CARE, 5'b00101, 4'd2);
      27: return mk(ALL_CARE, 5'b00010, 4'd3);
      28: return mk(ALL_CARE, 5'b00001, 4'd5);
      29: return mk(ALL_CARE, 5'b00000, 4'd6);
      default: return '0;
    endcase
  endfunction

  // 29-point table: five wildcard rows, three addresses never reached
  function automatic pla_row_t short_row(input int idx);
    case (idx)
      0:  return mk(5'b11110, 5'b11110, 4'd14);
      1:  return mk(5'b11101, 5'b01101, 4'd13);
      2:  return mk(5'b11110, 5'b10000, 4'd8);
      3:  return mk(5'b11011, 5'b01010, 4'd1);
      4:  return mk(5'b11101, 5'b10101, 4'd0);
      5:  return mk(ALL_CARE, 5'b01000, 4'd9);
      6:  return mk(ALL_CARE, 5'b10100, 4'd11);
      7:  return mk(ALL_CARE, 5'b11010, 4'd12);
      8:  return mk(ALL_CARE, 5'b00110, 4'd14);
      9:  return mk(ALL_CARE, 5'b10011, 4'd15);
      10: return mk(ALL_CARE, 5'b11001, 4'd15);
      11: return mk(ALL_CARE, 5'b11100, 4'd15);
      12: return mk(ALL_CARE, 5'b00111, 4'd11);
      13: return mk(ALL_CARE, 5'b00011, 4'd10);
      14: return mk(ALL_CARE, 5'b11000, 4'd7);
      15: return mk(ALL_CARE, 5'b01100, 4'd5);
      16: return mk(ALL_CARE, 5'b10110, 4'd4);
      17: return mk(ALL_CARE, 5'b11011, 4'd2);
      18: return mk(ALL_CARE, 5'b11101, 4'd1);
      19: return mk(ALL_CARE, 5'b01011, 4'd0);
      20: return mk(ALL_CARE, 5'b00101, 4'd2);
      21: return mk(ALL_CARE, 5'b00010, 4'd3);
      22: return mk(ALL_CARE, 5'b00001, 4'd4);
      23: return mk(ALL_CARE, 5'b00000, 4'd6);
      default: return '0;
    endcase
  endfunction

  function automatic pla_row_t pla_row(input int points, input int idx);
    return (points == SHORT_POINTS) ? short_row(idx) : full_row(idx);
  endfunction

endpackage

// File: rtl/sine_addr_nlfsr.sv
`timescale 1ns/1ps
module sine_addr_nlfsr
  import sine_seq_pkg::*;
#(
  parameter int POINTS = FULL_POINTS
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  output addr_t addr,
  output logic  wrap
);

  localparam int CNT_W = $clog2(POINTS + 1);

  logic             zero_escape_evt;
  logic             jump_evt;
  logic             new_bit;
  logic             land_seed_evt;
  addr_t            nxt_addr;
  logic [CNT_W-1:0] period_cnt;

  assign zero_escape_evt = upper_zero(addr);

  generate
    if (POINTS == SHORT_POINTS) begin : g_short
      assign jump_evt = (addr == JUMP_ADDR);

      // R4: the forced bit skips three states of the full cycle
      p_short_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && addr == JUMP_ADDR) |=> (addr == 5'b10100));
    end else begin : g_full
      assign jump_evt = 1'b0;

      p_full_no_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && addr == JUMP_ADDR) |=> (addr == 5'b00100));
    end
  endgenerate

  assign new_bit       = lin_tap(addr) ^ zero_escape_evt ^ jump_evt;
  assign nxt_addr      = shift_in(addr, new_bit);
  assign land_seed_evt = step && (nxt_addr == SEED_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr       <= SEED_ADDR;
      wrap       <= 1'b0;
      period_cnt <= '0;
    end else begin
      wrap <= land_seed_evt;
      if (step) begin
        addr       <= nxt_addr;
        period_cnt <= land_seed_evt ? '0 : period_cnt + 1'b1;
      end
    end
  end

  // R2: old bits move one place down on a step
  p_shift_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (addr[ADDR_W-2:0] == $past(addr[ADDR_W-1:1])));

  p_hold_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(addr));

  // R3: all-zero state is left, never held
  p_zero_escape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && addr == '0) |=> (addr == SEED_ADDR));

  // R3/R4: period closes after exactly POINTS steps
  p_period_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    land_seed_evt |-> (period_cnt == CNT_W'(POINTS - 1)));

  p_wrap_seed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (addr == SEED_ADDR));

endmodule

// File: rtl/sine_pla_lookup.sv
`timescale 1ns/1ps
module sine_pla_lookup
  import sine_seq_pkg::*;
#(
  parameter int POINTS = FULL_POINTS
) (
  input  logic    clk,
  input  logic    rst_n,
  input  addr_t   addr,
  output sample_t sample
);

  localparam int NROWS = row_count(POINTS);

  logic [NROWS-1:0] row_hit_vec;
  sample_t          row_term [NROWS];

  for (genvar i = 0; i < NROWS; i++) begin : g_row
    localparam pla_row_t ROW = pla_row(POINTS, i);
    assign row_hit_vec[i] = row_hit(ROW, addr);
    assign row_term[i]    = row_hit_vec[i] ? ROW.value : '0;
  end

  // OR plane: with one row active this is that row's value
  always_comb begin
    sample = '0;
    for (int i = 0; i < NROWS; i++) begin
      sample = sample | row_term[i];
    end
  end

  // R9: one and only one row answers each reachable address
  p_one_row_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_hit_vec) == 1);

endmodule

// File: rtl/sine_step_seq.sv
`timescale 1ns/1ps
module sine_step_seq
  import sine_seq_pkg::*;
#(
  parameter int POINTS = FULL_POINTS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  output logic [SAMPLE_W-1:0] sample,
  output logic [ADDR_W-1:0]   seq_addr,
  output logic                wrap
);

  addr_t   cur_addr;
  sample_t cur_sample;
  logic    wrap_evt;

  sine_addr_nlfsr #(.POINTS(POINTS)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .addr  (cur_addr),
    .wrap  (wrap_evt)
  );

  sine_pla_lookup #(.POINTS(POINTS)) u_pla (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (cur_addr),
    .sample (cur_sample)
  );

  assign sample   = cur_sample;
  assign seq_addr = cur_addr;
  assign wrap     = wrap_evt;

  p_sample_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(sample));

  // R10: the strobe marks the start sample and never lasts two cycles
  p_wrap_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (sample == 4'd8));

  p_wrap_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> !wrap);

  // R8: the start of a period is in the upper half-cycle
  p_start_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_addr == SEED_ADDR) |-> sample[SAMPLE_W-1]);

endmodule

// File: tb/sine_step_seq_test.sv
`timescale 1ns/1ps
module sine_step_seq_test;

  localparam real PI = 3.14159265358979;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  logic step  = 1'b0;

  logic [3:0] s32, s29;
  logic [4:0] a32, a29;
  logic       w32, w29;

  always #5 clk = ~clk;

  sine_step_seq #(.POINTS(32)) uut (
    .clk(clk), .rst_n(rst_n), .step(step),
    .sample(s32), .seq_addr(a32), .wrap(w32));

  sine_step_seq #(.POINTS(29)) uut_short (
    .clk(clk), .rst_n(rst_n), .step(step),
    .sample(s29), .seq_addr(a29), .wrap(w29));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int exp32 [32] = '{8,9,10,12,13,14,14,15,15,15,14,14,13,12,10,9,
                     7,6,5,3,2,1,1,0,0,0,1,1,2,3,5,6};
  int exp29 [29] = '{8,9,11,12,13,14,15,15,15,14,14,13,11,10,8,
                     7,5,4,2,1,1,0,0,0,1,2,3,4,6};

  int          kk [2];
  bit          ew [2];
  logic [4:0]  pa [2];
  logic [4:0]  lastobs [2];
  logic [31:0] seen [2];
  int          pbuf [2][32];
  int          pcnt [2];
  int          av [2][32];
  bit          lst = 0;
  bit          prev_rst = 0;

  function automatic int npts(input int m);
    return (m == 0) ? 32 : 29;
  endfunction

  function automatic int expv(input int m, input int k);
    return (m == 0) ? exp32[k] : exp29[k];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int ex);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, ex);
    end
  endtask

  task automatic reset_model();
    lst = 0;
    for (int m = 0; m < 2; m++) begin
      kk[m]   = 0;
      ew[m]   = 0;
      seen[m] = 32'h0001_0000;
      pcnt[m] = 0;
    end
  endtask

  // R7: cyclic count of direction changes over one observed period
  task automatic shape_check(input int m);
    int n, nd, peaks, troughs;
    int dl [32];
    n = npts(m); nd = 0; peaks = 0; troughs = 0;
    for (int i = 0; i < n; i++) begin
      int d;
      d = pbuf[m][(i + 1) % n] - pbuf[m][i];
      if (d != 0) begin
        dl[nd] = (d > 0) ? 1 : -1;
        nd++;
      end
    end
    for (int j = 0; j < nd; j++) begin
      if (dl[j] == 1 && dl[(j + 1) % nd] == -1) peaks++;
      if (dl[j] == -1 && dl[(j + 1) % nd] == 1) troughs++;
    end
    chk(peaks == 1, "R7 single peak", peaks, 1);
    chk(troughs == 1, "R7 single trough", troughs, 1);
  endtask

  task automatic observe_mode(input int m);
    logic [3:0] s;
    logic [4:0] a;
    logic       w;
    int         n;
    real        ideal, err;
    s = (m == 0) ? s32 : s29;
    a = (m == 0) ? a32 : a29;
    w = (m == 0) ? w32 : w29;
    n = npts(m);

    chk(int'(s) == expv(m, kk[m]), (m == 0) ? "R5 sample" : "R6 sample",
        s, expv(m, kk[m]));
    chk(w == ew[m], "R10 wrap strobe", w, ew[m]);
    chk(s[3] == (2 * kk[m] < n), "R8 half-cycle bit", s[3], (2 * kk[m] < n));
    ideal = 7.5 + 7.5 * $sin(2.0 * PI * kk[m] / n);
    err = real'(s) - ideal;
    if (err < 0.0) err = -err;
    chk(err <= 0.5001, "R7 within half a code", s, int'(ideal));

    if (!rst_n) begin
      chk(a == 5'b10000, "R1 reset address", a, 5'b10000);
      chk(s == 4'd8, "R1 reset sample", s, 8);
      chk(w == 1'b0, "R1 reset wrap", w, 0);
    end else begin
      av[m][a] = s;
    end

    if (lst) begin
      chk(a[3:0] == pa[m][4:1], "R2 shift right", a[3:0], pa[m][4:1]);
      if (kk[m] == 0) begin
        chk(a == 5'b10000, (m == 0) ? "R3 period end" : "R4 period end", a, 16);
        if (m == 0)
          chk(seen[m] == 32'hFFFF_FFFF, "R3 all addresses visited",
              $countones(seen[m]), 32);
        else
          chk($countones(seen[m]) == 29 && seen[m][0], "R4 29 addresses visited",
              $countones(seen[m]), 29);
        if (pcnt[m] == n) shape_check(m);
        pcnt[m] = 0;
        seen[m] = 32'h0001_0000;
      end else begin
        chk(!seen[m][a], (m == 0) ? "R3 no repeat" : "R4 no repeat", a, -1);
        seen[m][a] = 1'b1;
      end
      if (pcnt[m] < 32) begin
        pbuf[m][pcnt[m]] = s;
        pcnt[m]++;
      end
    end else begin
      if (rst_n && prev_rst)
        chk(a == lastobs[m], "R2 hold without step", a, lastobs[m]);
      if (pcnt[m] == 0) begin
        pbuf[m][0] = s;
        pcnt[m] = 1;
      end
    end
    lastobs[m] = a;
  endtask

  task automatic tick(input bit st);
    @(negedge clk);
    if (!done) begin
      observe_mode(0);
      observe_mode(1);
    end
    prev_rst = rst_n;
    step = st;
    lst  = st && rst_n;
    for (int m = 0; m < 2; m++) begin
      if (lst) begin
        pa[m] = (m == 0) ? a32 : a29;
        kk[m] = (kk[m] + 1) % npts(m);
        ew[m] = (kk[m] == 0);
      end else begin
        ew[m] = 1'b0;
      end
    end
  endtask

  initial begin
    int unsigned r;
    r = 32'h1234_5678;
    reset_model();
    repeat (3) tick(1'b0);
    rst_n = 1'b1;

    // back-to-back steps over several periods of both variants
    repeat (100) tick(1'b1);

    // irregular gaps between steps
    for (int i = 0; i < 260; i++) begin
      r = r * 32'd1103515245 + 32'd12345;
      tick(r[16]);
    end

    // reset in the middle of a period
    tick(1'b1);
    rst_n = 1'b0;
    step  = 1'b0;
    reset_model();
    tick(1'b0);
    tick(1'b0);
    rst_n = 1'b1;
    repeat (70) tick(1'b1);
    repeat (4) tick(1'b0);

    // R9: addresses that share a row carry equal samples
    chk(av[0][20] == av[0][28], "R9 shared row 10100/11100", av[0][28], av[0][20]);
    chk(av[0][21] == av[0][29], "R9 shared row 10101/11101", av[0][29], av[0][21]);
    chk(av[1][30] == av[1][31], "R9 shared row 11110/11111", av[1][31], av[1][30]);
    chk(av[1][13] == av[1][15], "R9 shared row 01101/01111", av[1][15], av[1][13]);
    chk(av[1][16] == av[1][17], "R9 shared row 10000/10001", av[1][17], av[1][16]);
    chk(av[1][10] == av[1][14], "R9 shared row 01010/01110", av[1][14], av[1][10]);
    chk(av[1][21] == av[1][23], "R9 shared row 10101/10111", av[1][23], av[1][21]);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule